// File: doc/BRIEF.md
# Two-Channel Background Read Sequencer

This block fetches a run of values from an external bus in the background and streams them into a shared read-data FIFO. Each of its two channels keeps a next-address register, an access width (byte, halfword or word) and a remaining-count register. Software starts a channel by writing a nonzero count, and stops it by writing zero. After each read that returns data, the address register steps by the access width. A cancelled channel is left holding the address it would have fetched next, so software can work out how many entries reached the FIFO.

The sequencer issues one read at a time on a request/acknowledge bus. Channel 0 always wins over channel 1. Results narrower than a word are right-aligned and zero-padded. The results leave on a valid/ready stream. `fifo_ready` low means the FIFO has no free slot. While it is low, no new read is issued, and a result already held stays on `fifo_data` with `fifo_valid` high until a cycle in which `fifo_ready` is high. A separate foreground port carries blocking single-word reads and writes. Such an access waits only for the read already in flight, uses the bus, and then the background sequence continues from the same address and count.

Top module: `nbr_sequencer`

## Requirements
- R1: After reset, every channel's address, width and count read back as zero, `bus_req` is low and `fifo_valid` is low.
- R2: Writing a nonzero count starts the channel. Its first bus read uses the channel's address register, and `bus_size` carries the width code (0 byte, 1 halfword, 2 word, 3 treated as word). Register field codes on `reg_wr_field`/`reg_rd_field` are 0 address, 1 width, 2 count.
- R3: Each read accepted for a channel advances that channel's address by 1, 2 or 4. Each result taken by the FIFO decrements the count. The channel stops issuing reads when the count reaches zero.
- R4: Writing zero to the count cancels the channel. A read still in flight is completed on the bus, but its data is dropped and the address is not advanced. No further reads follow, and the address register equals the start address plus the width times the number of entries delivered.
- R5: With both channels started, every channel 1 read comes after channel 0's count has reached zero.
- R6: A byte result occupies bits 7:0 of `fifo_data` and a halfword result occupies bits 15:0. All higher bits are zero.
- R7: No background read is issued while `fifo_ready` is low or a result is still held. A held result keeps `fifo_valid` high and `fifo_data` unchanged until it is accepted.
- R8: `bus_req`, `bus_addr` and `bus_size` stay stable from the cycle a request is raised until `bus_ack`, and at most one request is outstanding.
- R9: A foreground request is granted only once no background read is in flight. `fg_ack` marks its completion and `fg_rdata` returns read data. The background sequence then continues from the next address with its remaining count, and its data is unaffected.
- R10: Register reads return the current address, width and remaining count of the selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_ch | input | 1 | Channel selected for the write |
| reg_wr_field | input | 2 | Field written: 0 address, 1 width, 2 count |
| reg_wr_data | input | 32 | Write value |
| reg_rd_ch | input | 1 | Channel selected for readback |
| reg_rd_field | input | 2 | Field read back |
| reg_rd_data | output | 32 | Readback value (combinational) |
| bus_req | output | 1 | External access request |
| bus_we | output | 1 | External access is a write |
| bus_addr | output | 32 | External access address |
| bus_size | output | 2 | External access width code |
| bus_wdata | output | 32 | External write data |
| bus_ack | input | 1 | External access completes this cycle |
| bus_rdata | input | 32 | Right-aligned read data, valid with bus_ack |
| fifo_valid | output | 1 | Result available for the FIFO |
| fifo_data | output | 32 | Zero-extended result |
| fifo_ready | input | 1 | FIFO has a free slot |
| fg_req | input | 1 | Foreground access request, held until fg_ack |
| fg_we | input | 1 | Foreground access is a write |
| fg_addr | input | 32 | Foreground address |
| fg_wdata | input | 32 | Foreground write data |
| fg_ack | output | 1 | Foreground access complete |
| fg_rdata | output | 32 | Foreground read data, valid with fg_ack |

## Verification
A stepping error shows up within one transfer. The data the bench model returns is a function of the address, so a wrong next address gives a wrong FIFO word at the following push, and the address readback is off by one width at the end of the run. A wrong count makes the number of pushes differ from the count written, and this is visible within a few cycles of the run's end. A wrong arbitration or pause state shows in the order of logged bus accesses: a channel 1 address ahead of a channel 0 address, or a foreground grant overlapping a background request. A padding or hold fault appears on `fifo_data` in the very cycle the result is presented.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] FLD_ADDR  = 2'd0;
  localparam logic [1:0] FLD_SIZE  = 2'd1;
  localparam logic [1:0] FLD_COUNT = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NBR  = 2'd1,
    ST_FG   = 2'd2
  } bus_state_e;

  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_step = 3'd1;
      SZ_HALF: size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] zero_ext(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: zero_ext = {24'd0, d[7:0]};
      SZ_HALF: zero_ext = {16'd0, d[15:0]};
      default: zero_ext = d;
    endcase
  endfunction
endpackage

// File: rtl/nbr_channel.sv
module nbr_channel
  import nbr_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_field,
  input  logic [31:0]   wr_data,
  input  logic          adv,
  input  logic          dec,
  output logic [AW-1:0] addr,
  output logic [1:0]    size,
  output logic [CW-1:0] count,
  output logic          active
);
  logic wr_addr, wr_size, wr_count;

  assign wr_addr  = wr_en && (wr_field == FLD_ADDR);
  assign wr_size  = wr_en && (wr_field == FLD_SIZE);
  assign wr_count = wr_en && (wr_field == FLD_COUNT);
  assign active   = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (wr_addr) begin
      addr <= wr_data[AW-1:0];
    end else if (adv) begin
      addr <= addr + AW'(size_step(size));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size <= SZ_BYTE;
    end else if (wr_size) begin
      size <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_count) begin
      count <= wr_data[CW-1:0];
    end else if (dec && active) begin
      count <= count - 1'b1;
    end
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !wr_count) |=> !active); // R3
endmodule

// File: rtl/nbr_bus_ctrl.sv
module nbr_bus_ctrl
  import nbr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          ch_active,
  input  logic [NCH-1:0][AW-1:0]  ch_addr,
  input  logic [NCH-1:0][1:0]     ch_size,
  input  logic                    buf_busy,
  input  logic                    fifo_ready,
  input  logic                    fg_req,
  input  logic                    fg_we,
  input  logic [AW-1:0]           fg_addr,
  input  logic [31:0]             fg_wdata,
  output logic                    fg_ack,
  input  logic                    bus_ack,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [AW-1:0]           bus_addr,
  output logic [1:0]              bus_size,
  output logic [31:0]             bus_wdata,
  output logic                    cap_valid,
  output logic [CHW-1:0]          cap_ch,
  output logic [1:0]              cap_size
);
  bus_state_e     state_q;
  logic [CHW-1:0] owner_q;
  logic [CHW-1:0] pick;
  logic           any_active;
  logic           issue_ok;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ch_active[i]) pick = CHW'(i);
    end
  end

  assign any_active = |ch_active;
  assign issue_ok   = any_active && !buf_busy && fifo_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      owner_q   <= '0;
      bus_addr  <= '0;
      bus_size  <= SZ_BYTE;
      bus_we    <= 1'b0;
      bus_wdata <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (fg_req) begin
            state_q   <= ST_FG;
            bus_addr  <= fg_addr;
            bus_we    <= fg_we;
            bus_wdata <= fg_wdata;
            bus_size  <= SZ_WORD;
          end else if (issue_ok) begin
            state_q   <= ST_NBR;
            owner_q   <= pick;
            bus_addr  <= ch_addr[pick];
            bus_size  <= ch_size[pick];
            bus_we    <= 1'b0;
            bus_wdata <= '0;
          end
        end
        default: begin
          if (bus_ack) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign bus_req   = (state_q != ST_IDLE);
  assign fg_ack    = (state_q == ST_FG) && bus_ack;
  assign cap_valid = (state_q == ST_NBR) && bus_ack && ch_active[owner_q];
  assign cap_ch    = owner_q;
  assign cap_size  = bus_size;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_size))); // R8

  AST_NO_ISSUE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NBR && $past(state_q) == ST_IDLE) |-> ($past(fifo_ready) && !$past(buf_busy))); // R7

  AST_CH0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NBR && $past(state_q) == ST_IDLE && owner_q != '0) |-> !$past(ch_active[0])); // R5

  AST_FG_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NBR && !bus_ack) |=> !fg_ack); // R9
endmodule

// File: rtl/nbr_push_buf.sv
module nbr_push_buf
  import nbr_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_valid,
  input  logic [CHW-1:0] cap_ch,
  input  logic [1:0]     cap_size,
  input  logic [31:0]    cap_data,
  output logic           fifo_valid,
  output logic [31:0]    fifo_data,
  input  logic           fifo_ready,
  output logic           pop,
  output logic [CHW-1:0] pop_ch
);
  logic [1:0] held_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_valid <= 1'b0;
      fifo_data  <= '0;
      pop_ch     <= '0;
      held_size  <= SZ_BYTE;
    end else if (cap_valid) begin
      fifo_valid <= 1'b1;
      fifo_data  <= zero_ext(cap_data, cap_size);
      pop_ch     <= cap_ch;
      held_size  <= cap_size;
    end else if (pop) begin
      fifo_valid <= 1'b0;
    end
  end

  assign pop = fifo_valid && fifo_ready;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && !fifo_ready) |=> (fifo_valid && $stable(fifo_data))); // R7

  AST_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && held_size == SZ_BYTE) |-> (fifo_data[31:8] == 24'd0)); // R6

  AST_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && held_size == SZ_HALF) |-> (fifo_data[31:16] == 16'd0)); // R6
endmodule

// File: rtl/nbr_sequencer.sv
module nbr_sequencer
  import nbr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic [CHW-1:0] reg_wr_ch,
  input  logic [1:0]     reg_wr_field,
  input  logic [31:0]    reg_wr_data,
  input  logic [CHW-1:0] reg_rd_ch,
  input  logic [1:0]     reg_rd_field,
  output logic [31:0]    reg_rd_data,
  output logic           bus_req,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [1:0]     bus_size,
  output logic [31:0]    bus_wdata,
  input  logic           bus_ack,
  input  logic [31:0]    bus_rdata,
  output logic           fifo_valid,
  output logic [31:0]    fifo_data,
  input  logic           fifo_ready,
  input  logic           fg_req,
  input  logic           fg_we,
  input  logic [AW-1:0]  fg_addr,
  input  logic [31:0]    fg_wdata,
  output logic           fg_ack,
  output logic [31:0]    fg_rdata
);
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][1:0]    ch_size;
  logic [NCH-1:0][CW-1:0] ch_count;
  logic [NCH-1:0]         ch_active;
  logic                   cap_valid;
  logic [CHW-1:0]         cap_ch;
  logic [1:0]             cap_size;
  logic                   pop;
  logic [CHW-1:0]         pop_ch;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    nbr_channel #(.AW(AW), .CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en && (reg_wr_ch == CHW'(g))),
      .wr_field (reg_wr_field),
      .wr_data  (reg_wr_data),
      .adv      (cap_valid && (cap_ch == CHW'(g))),
      .dec      (pop && (pop_ch == CHW'(g))),
      .addr     (ch_addr[g]),
      .size     (ch_size[g]),
      .count    (ch_count[g]),
      .active   (ch_active[g])
    );
  end

  nbr_bus_ctrl #(.NCH(NCH), .AW(AW)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_active  (ch_active),
    .ch_addr    (ch_addr),
    .ch_size    (ch_size),
    .buf_busy   (fifo_valid),
    .fifo_ready (fifo_ready),
    .fg_req     (fg_req),
    .fg_we      (fg_we),
    .fg_addr    (fg_addr),
    .fg_wdata   (fg_wdata),
    .fg_ack     (fg_ack),
    .bus_ack    (bus_ack),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .cap_valid  (cap_valid),
    .cap_ch     (cap_ch),
    .cap_size   (cap_size)
  );

  nbr_push_buf #(.NCH(NCH)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_valid  (cap_valid),
    .cap_ch     (cap_ch),
    .cap_size   (cap_size),
    .cap_data   (bus_rdata),
    .fifo_valid (fifo_valid),
    .fifo_data  (fifo_data),
    .fifo_ready (fifo_ready),
    .pop        (pop),
    .pop_ch     (pop_ch)
  );

  assign fg_rdata = bus_rdata;

  always_comb begin
    case (reg_rd_field)
      FLD_ADDR:  reg_rd_data = 32'(ch_addr[reg_rd_ch]);
      FLD_SIZE:  reg_rd_data = {30'd0, ch_size[reg_rd_ch]};
      FLD_COUNT: reg_rd_data = 32'(ch_count[reg_rd_ch]);
      default:   reg_rd_data = '0;
    endcase
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    fg_ack |-> !cap_valid); // R9
endmodule

// File: tb/nbr_sequencer_tb.sv
`timescale 1ns/1ps
module nbr_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [0:0]  reg_wr_ch = '0;
  logic [1:0]  reg_wr_field = '0;
  logic [31:0] reg_wr_data = '0;
  logic [0:0]  reg_rd_ch = '0;
  logic [1:0]  reg_rd_field = '0;
  logic [31:0] reg_rd_data;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0]  bus_size;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        fifo_valid;
  logic [31:0] fifo_data;
  logic        fifo_ready = 1'b1;
  logic        fg_req = 1'b0, fg_we = 1'b0;
  logic [31:0] fg_addr = '0, fg_wdata = '0;
  logic        fg_ack;
  logic [31:0] fg_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nbr_sequencer u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_ch(reg_wr_ch), .reg_wr_field(reg_wr_field),
    .reg_wr_data(reg_wr_data), .reg_rd_ch(reg_rd_ch), .reg_rd_field(reg_rd_field),
    .reg_rd_data(reg_rd_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
    .fg_req(fg_req), .fg_we(fg_we), .fg_addr(fg_addr), .fg_wdata(fg_wdata),
    .fg_ack(fg_ack), .fg_rdata(fg_rdata)
  );

  function automatic logic [31:0] mem(input logic [31:0] a);
    mem = {a[7:0] ^ 8'h5A, a[15:8] + 8'h3C, ~a[7:0], a[7:0] + 8'h81};
  endfunction

  function automatic logic [31:0] expect_data(input logic [31:0] a, input int sz);
    logic [31:0] m;
    m = mem(a);
    if (sz == 0) expect_data = {24'd0, m[7:0]};
    else if (sz == 1) expect_data = {16'd0, m[15:0]};
    else expect_data = m;
  endfunction

  // Bus model: ack two cycles after a request appears; logs every access.
  logic [31:0] tx_addr [0:511];
  logic        tx_we   [0:511];
  int          ntx = 0;
  logic [1:0]  lat = '0;
  logic        p_req = 1'b0, p_ack = 1'b0;
  logic [31:0] p_addr = '0;
  int          hold_viol = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      lat <= '0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        if (lat == 2'd1) begin
          bus_ack <= 1'b1;
          bus_rdata <= mem(bus_addr);
          lat <= '0;
          if (ntx < 512) begin
            tx_addr[ntx] = bus_addr;
            tx_we[ntx] = bus_we;
          end
          ntx = ntx + 1;
        end else begin
          lat <= lat + 1'b1;
        end
      end
      if (p_req && !p_ack && (!bus_req || bus_addr != p_addr)) hold_viol = hold_viol + 1;
      p_req = bus_req;
      p_ack = bus_ack;
      p_addr = bus_addr;
    end
  end

  // FIFO sink model
  logic [31:0] push_data [0:511];
  int          npush = 0;
  logic        pv = 1'b0, pr = 1'b0;
  logic [31:0] pd = '0;
  int          out_viol = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (pv && !pr && (!fifo_valid || fifo_data != pd)) out_viol = out_viol + 1;
      if (fifo_valid && fifo_ready) begin
        if (npush < 512) push_data[npush] = fifo_data;
        npush = npush + 1;
      end
      pv = fifo_valid;
      pr = fifo_ready;
      pd = fifo_data;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input int ch, input int fld, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_ch = 1'(ch); reg_wr_field = 2'(fld); reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rreg(input int ch, input int fld, output logic [31:0] d);
    reg_rd_ch = 1'(ch); reg_rd_field = 2'(fld);
    #1;
    d = reg_rd_data;
  endtask

  task automatic wait_push(input int target);
    for (int k = 0; k < 600 && npush < target; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic fg_access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                           output logic [31:0] rd);
    @(negedge clk);
    fg_req = 1'b1; fg_we = we; fg_addr = a; fg_wdata = wd;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (fg_ack) break;
    end
    rd = fg_rdata;
    check(fg_ack, "R9 fg_ack seen", {31'd0, fg_ack}, 32'd1);
    fg_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int np0, nt0, step;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: reset state
    for (int ch = 0; ch < 2; ch++)
      for (int f = 0; f < 3; f++) begin
        rreg(ch, f, v);
        check(v == 0, "R1 reset register", v, 0);
      end
    check(!bus_req && !fifo_valid, "R1 idle outputs", {30'd0, bus_req, fifo_valid}, 0);

    // R2 R3 R6 R10: sweep channel, width, count, start address
    for (int ch = 0; ch < 2; ch++)
      for (int sz = 0; sz < 3; sz++)
        for (int n = 1; n <= 3; n++)
          for (int ai = 0; ai < 2; ai++) begin
            logic [31:0] a0;
            a0 = (ai == 0) ? 32'h0000_0100 : 32'h0000_12FF;
            step = 1 << sz;
            np0 = npush; nt0 = ntx;
            wreg(ch, 0, a0);
            wreg(ch, 1, sz);
            rreg(ch, 1, v);
            check(v == sz, "R10 width readback", v, sz);
            wreg(ch, 2, n);
            wait_push(np0 + n);
            check(npush - np0 == n, "R3 push count", npush - np0, n);
            check(tx_addr[nt0] == a0, "R2 first address", tx_addr[nt0], a0);
            for (int i = 0; i < n; i++)
              check(push_data[np0 + i] == expect_data(a0 + i * step, sz), "R6 data",
                    push_data[np0 + i], expect_data(a0 + i * step, sz));
            rreg(ch, 0, v);
            check(v == a0 + n * step, "R3 final address", v, a0 + n * step);
            rreg(ch, 2, v);
            check(v == 0, "R3 count reaches zero", v, 0);
          end

    // R7 / R5: hold back, start both channels, release
    fifo_ready = 1'b0;
    nt0 = ntx; np0 = npush;
    wreg(1, 0, 32'h400); wreg(1, 1, 0); wreg(1, 2, 2);
    wreg(0, 0, 32'h200); wreg(0, 1, 2); wreg(0, 2, 3);
    repeat (20) @(negedge clk);
    check(ntx == nt0, "R7 no read while not ready", ntx - nt0, 0);
    fifo_ready = 1'b1;
    wait_push(np0 + 5);
    check(tx_addr[nt0] == 32'h200 && tx_addr[nt0 + 1] == 32'h204 && tx_addr[nt0 + 2] == 32'h208,
          "R5 channel 0 first", tx_addr[nt0 + 2], 32'h208);
    check(tx_addr[nt0 + 3] == 32'h400 && tx_addr[nt0 + 4] == 32'h401, "R5 channel 1 after",
          tx_addr[nt0 + 3], 32'h400);
    check(push_data[np0 + 3] == expect_data(32'h400, 0), "R5 R6 ch1 data",
          push_data[np0 + 3], expect_data(32'h400, 0));

    // R7: toggling back-pressure, data order and hold
    np0 = npush;
    wreg(0, 0, 32'h3000); wreg(0, 1, 1); wreg(0, 2, 6);
    for (int k = 0; k < 200 && npush < np0 + 6; k++) begin
      @(negedge clk);
      fifo_ready = (k % 3) != 0;
    end
    fifo_ready = 1'b1;
    wait_push(np0 + 6);
    check(npush - np0 == 6, "R7 all delivered", npush - np0, 6);
    for (int i = 0; i < 6; i++)
      check(push_data[np0 + i] == expect_data(32'h3000 + 2 * i, 1), "R7 data under stall",
            push_data[np0 + i], expect_data(32'h3000 + 2 * i, 1));
    check(out_viol == 0, "R7 held output stable", out_viol, 0);

    // R4: cancel mid-sequence
    np0 = npush; nt0 = ntx;
    wreg(0, 0, 32'h100); wreg(0, 1, 0); wreg(0, 2, 10);
    for (int k = 0; k < 200 && ntx < nt0 + 4; k++) @(negedge clk);
    wreg(0, 2, 0);
    repeat (15) @(negedge clk);
    nt0 = ntx;
    rreg(0, 0, v);
    check(v == 32'h100 + (npush - np0), "R4 next address kept", v, 32'h100 + (npush - np0));
    check(npush - np0 >= 4 && npush - np0 < 10, "R4 stopped early", npush - np0, 4);
    rreg(0, 2, v);
    check(v == 0, "R4 count cleared", v, 0);
    repeat (15) @(negedge clk);
    check(ntx == nt0, "R4 no reads after cancel", ntx - nt0, 0);
    for (int i = 0; i < npush - np0; i++)
      check(push_data[np0 + i] == expect_data(32'h100 + i, 0), "R4 delivered data",
            push_data[np0 + i], expect_data(32'h100 + i, 0));

    // R9: foreground accesses in the middle of a sequence
    np0 = npush; nt0 = ntx;
    wreg(0, 0, 32'h800); wreg(0, 1, 2); wreg(0, 2, 4);
    for (int k = 0; k < 200 && npush < np0 + 1; k++) @(negedge clk);
    fg_access(1'b1, 32'hF00, 32'hCAFE_0001, v);
    fg_access(1'b0, 32'hF04, 32'h0, v);
    check(v == mem(32'hF04), "R9 fg read data", v, mem(32'hF04));
    wait_push(np0 + 4);
    check(npush - np0 == 4, "R9 sequence resumed", npush - np0, 4);
    for (int i = 0; i < 4; i++)
      check(push_data[np0 + i] == expect_data(32'h800 + 4 * i, 2), "R9 data after pause",
            push_data[np0 + i], expect_data(32'h800 + 4 * i, 2));
    begin
      int nb, fgw;
      nb = 0; fgw = 0;
      for (int i = nt0; i < ntx; i++) begin
        if (tx_addr[i] == 32'hF00 && tx_we[i]) fgw = i;
        else if (tx_addr[i] != 32'hF04) begin
          check(tx_addr[i] == 32'h800 + 4 * nb, "R9 resume address", tx_addr[i], 32'h800 + 4 * nb);
          nb++;
        end
      end
      check(fgw > nt0, "R9 fg after in-flight read", fgw, nt0 + 1);
    end
    rreg(0, 0, v);
    check(v == 32'h810, "R9 final address", v, 32'h810);

    check(hold_viol == 0, "R8 request held until ack", hold_viol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule